// File: doc/BRIEF.md
# Partitioned SIMD Vector Lane ALU

This block is the integer arithmetic unit of one 64-bit vector lane. Each operation splits the lane into eight 8-bit, four 16-bit, two 32-bit or one 64-bit element. All elements are processed at once and no carry crosses from one element into the next. The unit adds, subtracts, ANDs, ORs and shifts left or right. Add and subtract read their elements as signed or unsigned values and either wrap or clamp at the limits of the element.

The second operand is another vector, or a scalar copied into every element. The scalar may stand on either side of the operator, so subtraction works in both directions. A mask of one flag per element can choose which elements get the new value. An element that is masked off takes its old destination contents, which arrive on a separate input. The result is registered one cycle after the request, and a valid strobe comes out with it.

Top module: `lane_simd_alu`

## Requirements
- R1: `elem_w` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i occupies bits [i*EW +: EW], and no carry, borrow or shifted bit crosses an element boundary.
- R2: `op_code` selects the operation: 0 add, 1 subtract (a minus b), 2 bitwise AND, 3 bitwise OR, 4 shift left, 5 shift right.
- R3: With `saturate` at 0, add and subtract give the true result modulo 2^EW, whatever the setting of `is_signed`.
- R4: With `saturate` at 1 and `is_signed` at 1, an add or subtract that goes past the signed range gives 2^(EW-1)-1 on positive overflow and -2^(EW-1) on negative overflow.
- R5: With `saturate` at 1 and `is_signed` at 0, an add or subtract gives all-ones when the result is above 2^EW-1 and zero when it is below zero.
- R6: `form` selects the operands. 0 gives a=`vec_a`, b=`vec_b`. 1 gives a=`vec_a`, b=the scalar. 2 gives a=the scalar, b=`vec_a`. The scalar is the low EW bits of `scal`, copied into every element.
- R7: Both shifts are logical and fill with zeros. The shift amount of each element is the b element modulo EW. `is_signed` and `saturate` have no effect on AND, OR or the shifts.
- R8: With `masked` at 1, element i of the result takes the new value only when `flags[i]` is 1. Otherwise it takes the matching element of `old_dst`. With `masked` at 0, `flags` is ignored.
- R9: `out_valid` is `in_valid` delayed by one clock. `result` shows the outcome of a request one clock after it is accepted, and it holds its value in cycles where `in_valid` is 0.
- R10: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 3 | Operation select |
| elem_w | input | 2 | Element width code |
| is_signed | input | 1 | Signed interpretation for add/subtract |
| saturate | input | 1 | Clamp instead of wrap |
| form | input | 2 | Operand form |
| masked | input | 1 | Enable per-element write mask |
| vec_a | input | 64 | First vector operand |
| vec_b | input | 64 | Second vector operand |
| scal | input | 64 | Scalar operand (low EW bits used) |
| flags | input | 8 | Per-element write flags |
| old_dst | input | 64 | Previous destination contents |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered lane result |

## Verification
Clamping and the write mask can act on the same element in one cycle, and neither may change what the other decides. To provoke this, the bench issues 8-bit signed and unsigned saturating adds in which every element overflows, with the mask on and alternating flags. The written elements must show the clamp value and the masked-off elements must show `old_dst` unchanged. A random sweep then compares every width, form and mode against a per-element model written independently in the bench.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    FORM_VV = 2'd0,
    FORM_VS = 2'd1,
    FORM_SV = 2'd2
  } opnd_form_e;

  // Returns {overflow, value}; value is wrapped or clamped per sat.
  function automatic logic [64:0] addsub_elem(input logic [63:0] a,
                                              input logic [63:0] b,
                                              input int unsigned ew,
                                              input logic sub,
                                              input logic sgn,
                                              input logic sat);
    logic [65:0] ax, bx, r, hi;
    logic [63:0] m, wrap, clamp;
    logic        ovf;
    m  = (ew >= 64) ? '1 : ((64'd1 << ew) - 64'd1);
    ax = {2'b00, a & m};
    bx = {2'b00, b & m};
    if (sgn && a[ew-1]) ax = ax | ~{2'b00, m};
    if (sgn && b[ew-1]) bx = bx | ~{2'b00, m};
    r    = sub ? (ax - bx) : (ax + bx);
    wrap = r[63:0] & m;
    if (sgn) begin
      hi    = r >> (ew - 1);
      ovf   = !((hi == '0) || (hi == ({66{1'b1}} >> (ew - 1))));
      clamp = r[65] ? ((m >> 1) + 64'd1) & m : (m >> 1);
    end else begin
      ovf   = (r >> ew) != '0;
      clamp = r[65] ? 64'd0 : m;
    end
    return {ovf, (sat && ovf) ? clamp : wrap};
  endfunction

  function automatic logic [63:0] shift_elem(input logic [63:0] a,
                                             input logic [63:0] b,
                                             input int unsigned ew,
                                             input logic left);
    logic [63:0] m;
    int unsigned amt;
    m   = (ew >= 64) ? '1 : ((64'd1 << ew) - 64'd1);
    amt = int'(b[5:0]) & (ew - 1);
    return left ? ((a << amt) & m) : ((a & m) >> amt);
  endfunction

endpackage

// File: rtl/lane_opnd_route.sv
module lane_opnd_route
  import lane_alu_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int NW     = 4
) (
  input  logic [1:0]        form,
  input  logic [1:0]        elem_w,
  input  logic [LANE_W-1:0] vec_a,
  input  logic [LANE_W-1:0] vec_b,
  input  logic [LANE_W-1:0] scal,
  output logic [LANE_W-1:0] opa,
  output logic [LANE_W-1:0] opb
);
  logic [LANE_W-1:0] bcast [NW];
  logic [LANE_W-1:0] bsel;

  for (genvar k = 0; k < NW; k++) begin : g_bc
    localparam int EW = 8 << k;
    assign bcast[k] = {(LANE_W / EW){scal[EW-1:0]}};
  end

  assign bsel = bcast[elem_w];

  always_comb begin
    case (opnd_form_e'(form))
      FORM_VS: begin opa = vec_a; opb = bsel;  end
      FORM_SV: begin opa = bsel;  opb = vec_a; end
      default: begin opa = vec_a; opb = vec_b; end
    endcase
  end
endmodule

// File: rtl/lane_width_slice.sv
module lane_width_slice
  import lane_alu_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int EW     = 8
) (
  input  alu_op_e           op,
  input  logic              sgn,
  input  logic              sat,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] res,
  output logic              ovf_any
);
  localparam int NE = LANE_W / EW;
  logic [NE-1:0] ovf;

  for (genvar i = 0; i < NE; i++) begin : g_el
    logic [EW-1:0] ea, eb, r;
    logic [64:0]   as_r;
    logic [63:0]   sh_r;
    assign ea   = a[i*EW +: EW];
    assign eb   = b[i*EW +: EW];
    assign as_r = addsub_elem(64'(ea), 64'(eb), EW, op == OP_SUB, sgn, sat);
    assign sh_r = shift_elem(64'(ea), 64'(eb), EW, op == OP_SHL);
    always_comb begin
      case (op)
        OP_ADD, OP_SUB: r = as_r[EW-1:0];
        OP_AND:         r = ea & eb;
        OP_OR:          r = ea | eb;
        OP_SHL, OP_SHR: r = sh_r[EW-1:0];
        default:        r = '0;
      endcase
    end
    assign res[i*EW +: EW] = r;
    assign ovf[i] = ((op == OP_ADD) || (op == OP_SUB)) && as_r[64];
  end

  assign ovf_any = |ovf;
endmodule

// File: rtl/lane_wb_merge.sv
module lane_wb_merge #(
  parameter int LANE_W = 64
) (
  input  logic                  masked,
  input  logic [1:0]            elem_w,
  input  logic [LANE_W/8-1:0]   flags,
  input  logic [LANE_W-1:0]     new_res,
  input  logic [LANE_W-1:0]     old_dst,
  output logic [LANE_W-1:0]     merged
);
  localparam int NB = LANE_W / 8;
  logic [NB-1:0] byte_en;

  always_comb begin
    for (int j = 0; j < NB; j++) begin
      byte_en[j] = !masked || flags[j >> elem_w];
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign merged[j*8 +: 8] = byte_en[j] ? new_res[j*8 +: 8] : old_dst[j*8 +: 8];
  end
endmodule

// File: rtl/lane_simd_alu.sv
module lane_simd_alu
  import lane_alu_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        elem_w,
  input  logic              is_signed,
  input  logic              saturate,
  input  logic [1:0]        form,
  input  logic              masked,
  input  logic [LANE_W-1:0] vec_a,
  input  logic [LANE_W-1:0] vec_b,
  input  logic [LANE_W-1:0] scal,
  input  logic [LANE_W/8-1:0] flags,
  input  logic [LANE_W-1:0] old_dst,
  output logic              out_valid,
  output logic [LANE_W-1:0] result
);
  localparam int NW = 4;

  alu_op_e           op;
  logic [LANE_W-1:0] opa, opb, lane_res, merged;
  logic [LANE_W-1:0] res_w [NW];
  logic [NW-1:0]     ovf_w;
  logic              sat_hit;

  assign op = alu_op_e'(op_code);

  lane_opnd_route #(.LANE_W(LANE_W), .NW(NW)) u_route (
    .form(form), .elem_w(elem_w), .vec_a(vec_a), .vec_b(vec_b),
    .scal(scal), .opa(opa), .opb(opb)
  );

  for (genvar k = 0; k < NW; k++) begin : g_w
    lane_width_slice #(.LANE_W(LANE_W), .EW(8 << k)) u_slice (
      .op(op), .sgn(is_signed), .sat(saturate), .a(opa), .b(opb),
      .res(res_w[k]), .ovf_any(ovf_w[k])
    );
  end

  assign lane_res = res_w[elem_w];
  assign sat_hit  = saturate && ovf_w[elem_w];

  lane_wb_merge #(.LANE_W(LANE_W)) u_merge (
    .masked(masked), .elem_w(elem_w), .flags(flags),
    .new_res(lane_res), .old_dst(old_dst), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end
endmodule

// File: rtl/lane_simd_alu_chk.sv
module lane_simd_alu_chk #(
  parameter int LANE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_code,
  input logic [1:0]        elem_w,
  input logic              is_signed,
  input logic [1:0]        form,
  input logic              masked,
  input logic [LANE_W-1:0] vec_a,
  input logic [LANE_W-1:0] vec_b,
  input logic [LANE_W/8-1:0] flags,
  input logic [LANE_W-1:0] old_dst,
  input logic              sat_hit,
  input logic              out_valid,
  input logic [LANE_W-1:0] result
);
  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  assert_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && masked && flags == '0) |=> result == $past(old_dst));

  assert_and_vv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !masked && op_code == 3'd2 && form == 2'd0)
      |=> result == $past(vec_a & vec_b));

  assert_unsigned_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_hit && !masked && !is_signed && op_code == 3'd0 && elem_w == 2'd3)
      |=> result == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R10: assert (out_valid == 1'b0 || $past(rst_n));
    end
  end
endmodule

bind lane_simd_alu lane_simd_alu_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .elem_w(elem_w), .is_signed(is_signed), .form(form), .masked(masked),
  .vec_a(vec_a), .vec_b(vec_b), .flags(flags), .old_dst(old_dst),
  .sat_hit(sat_hit), .out_valid(out_valid), .result(result)
);

// File: tb/lane_simd_alu_tb.sv
module lane_simd_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  elem_w = '0;
  logic        is_signed = 1'b0;
  logic        saturate = 1'b0;
  logic [1:0]  form = '0;
  logic        masked = 1'b0;
  logic [63:0] vec_a = '0, vec_b = '0, scal = '0, old_dst = '0;
  logic [7:0]  flags = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lane_simd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .elem_w(elem_w), .is_signed(is_signed), .saturate(saturate), .form(form),
    .masked(masked), .vec_a(vec_a), .vec_b(vec_b), .scal(scal),
    .flags(flags), .old_dst(old_dst), .out_valid(out_valid), .result(result)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Independent per-element reference.
  function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] w,
      input logic sg, input logic st, input logic [1:0] fm, input logic mk,
      input logic [7:0] fl, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] s, input logic [63:0] od);
    int ew = 8 << w;
    int ne = 8 >> w;
    logic [63:0] m = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
    logic [63:0] out = '0;
    for (int i = 0; i < ne; i++) begin
      logic [63:0] ea, eb, ev, sc;
      logic signed [65:0] va, vb, r, hi, lo;
      sc = s & m;
      ea = (a >> (i * ew)) & m;
      eb = (b >> (i * ew)) & m;
      if (fm == 2'd1) eb = sc;
      else if (fm == 2'd2) begin eb = ea; ea = sc; end
      va = $signed({2'b00, ea});
      vb = $signed({2'b00, eb});
      if (sg && ea[ew-1]) va = va - (66'sd1 <<< ew);
      if (sg && eb[ew-1]) vb = vb - (66'sd1 <<< ew);
      case (op)
        3'd0, 3'd1: begin
          r = (op == 3'd0) ? va + vb : va - vb;
          hi = sg ? ((66'sd1 <<< (ew - 1)) - 1) : $signed({2'b00, m});
          lo = sg ? -(66'sd1 <<< (ew - 1)) : 66'sd0;
          if (st && r > hi) r = hi;
          if (st && r < lo) r = lo;
          ev = r[63:0] & m;
        end
        3'd2: ev = ea & eb;
        3'd3: ev = ea | eb;
        3'd4: ev = (ea << (eb % ew)) & m;
        3'd5: ev = ea >> (eb % ew);
        default: ev = '0;
      endcase
      if (mk && !fl[i]) ev = (od >> (i * ew)) & m;
      out = out | (ev << (i * ew));
    end
    return out;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] w, input logic sg,
      input logic st, input logic [1:0] fm, input logic mk, input logic [7:0] fl,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] s,
      input logic [63:0] od);
    @(negedge clk);
    op_code = op; elem_w = w; is_signed = sg; saturate = st; form = fm;
    masked = mk; flags = fl; vec_a = a; vec_b = b; scal = s; old_dst = od;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R10 result in reset", result, 64'd0);
  endtask

  task automatic t_wrap;
    issue(3'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, 0, 0);
    check("R3 R1 8-bit wrap add", result, 64'h8080808080808080);
    check("R9 out_valid after request", {63'd0, out_valid}, 64'd1);
    issue(3'd0, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, '1, 64'd1, 0, 0);
    check("R3 64-bit wrap add", result, 64'd0);
    issue(3'd0, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 64'h0000FFFF0000FFFF, 64'h0000000100000001, 0, 0);
    check("R1 no carry across 16-bit elements", result, 64'h0000000000000000);
  endtask

  task automatic t_sat;
    issue(3'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 8'h00, 64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, 0, 0);
    check("R4 8-bit signed clamp high", result, 64'h7F7F7F7F7F7F7F7F);
    issue(3'd1, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 8'h00, 64'h8000000080000000, 64'h0000000100000001, 0, 0);
    check("R4 32-bit signed clamp low", result, 64'h8000000080000000);
    issue(3'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 64'h8000000080000000, 64'h0000000100000001, 0, 0);
    check("R3 32-bit signed wrap sub", result, 64'h7FFFFFFF7FFFFFFF);
    issue(3'd0, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 8'h00, 64'hFFF0FFF0FFF0FFF0, 64'h0020002000200020, 0, 0);
    check("R5 16-bit unsigned clamp high", result, 64'hFFFFFFFFFFFFFFFF);
    issue(3'd1, 2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 8'h00, 64'h0000000500000009, 64'h0000000700000002, 0, 0);
    check("R5 32-bit unsigned clamp zero", result, 64'h0000000000000007);
  endtask

  task automatic t_forms;
    issue(3'd1, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 8'h00, 64'h0003000300030003, '0, 64'hAAAA0010, 0);
    check("R6 scalar-vector subtract", result, 64'h000D000D000D000D);
    issue(3'd1, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 8'h00, 64'h0003000300030003, '1, 64'hAAAA0010, 0);
    check("R6 vector-scalar subtract", result, 64'hFFF3FFF3FFF3FFF3);
  endtask

  task automatic t_logic_shift;
    issue(3'd2, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_00FF_FFFF, 0, 0);
    check("R2 AND", result, 64'hF000_1234_00FF_0000);
    issue(3'd3, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 8'h00, 64'hF0F0_0000_0000_0001, 64'h0F00_0000_1000_0000, 0, 0);
    check("R2 R7 OR ignores sign/sat", result, 64'hFFF0_0000_1000_0001);
    issue(3'd4, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0, 8'h00, 64'h8181818181818181, '0, 64'd9, 0);
    check("R7 shift left amount mod 8", result, 64'h0202020202020202);
    issue(3'd5, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 64'h8000800080008000, 64'h0011001100110011, 0, 0);
    check("R7 logical shift right mod 16", result, 64'h4000400040004000);
  endtask

  task automatic t_mask;
    issue(3'd0, 2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 8'b1111_0101, 64'h0001000100010001, 64'h0001000100010001, 0, 64'hAAAABBBBCCCCDDDD);
    check("R8 16-bit mask flags 0,2", result, 64'hAAAA0002CCCC0002);
    issue(3'd0, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 64'h0001000100010001, 64'h0001000100010001, 0, 64'hAAAABBBBCCCCDDDD);
    check("R8 unmasked ignores flags", result, 64'h0002000200020002);
    // saturation and masking on the same elements
    issue(3'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 8'b0101_0101, 64'h7F7F7F7F7F7F7F7F, 64'h7F7F7F7F7F7F7F7F, 0, 64'h1122334455667788);
    check("R4 R8 clamp with mask", result, 64'h117F337F557F777F);
    issue(3'd0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 8'b1010_1010, 64'hF0F0F0F0F0F0F0F0, 64'hF0F0F0F0F0F0F0F0, 0, 64'h1122334455667788);
    check("R5 R8 clamp with mask", result, 64'hFF22FF44FF66FF88);
  endtask

  task automatic t_idle;
    logic [63:0] held;
    held = result;
    @(negedge clk);
    vec_a = 64'h1234; vec_b = 64'h5678; op_code = 3'd0;
    @(negedge clk);
    check("R9 result holds without valid", result, held);
    check("R9 out_valid low without valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      logic [2:0]  op = 3'($urandom_range(0, 5));
      logic [1:0]  w  = 2'($urandom_range(0, 3));
      logic        sg = 1'($urandom);
      logic        st = 1'($urandom);
      logic [1:0]  fm = 2'($urandom_range(0, 2));
      logic        mk = 1'($urandom);
      logic [7:0]  fl = 8'($urandom);
      logic [63:0] a  = {$urandom, $urandom};
      logic [63:0] b  = {$urandom, $urandom};
      logic [63:0] s  = {$urandom, $urandom};
      logic [63:0] od = {$urandom, $urandom};
      issue(op, w, sg, st, fm, mk, fl, a, b, s, od);
      check("R1 R2 R3 R4 R5 R6 R7 R8 random sweep", result,
            model(op, w, sg, st, fm, mk, fl, a, b, s, od));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wrap();
    t_sat();
    t_forms();
    t_logic_shift();
    t_mask();
    t_idle();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule